// File: doc/BRIEF.md
# Fixed-Priority Interrupt Request Controller

This block sits between a group of peripheral interrupt request lines and one processor interrupt input. It brings the request lines into its clock domain through a two-stage synchronizer, removes the lines that software has masked, and picks the raised line with the smallest index. The chosen index is added to a programmable 8-bit base to form an interrupt vector. The vector is latched into a readable register and the processor interrupt output is raised.

The controller then waits. The latched vector and the interrupt output hold, whatever the request lines do, until the processor writes to the vector register address as an acknowledge. That write drops the interrupt output. The controller then goes back to arbitrating the current synchronized, unmasked requests. Request lines are treated as levels, so a peripheral that is still requesting after the acknowledge is served again.

Software reaches three registers over a small bus with a write strobe and a combinational read port. The vector register is at address 0: reads return the last latched vector and writes act as the acknowledge. The vector base is at address 1 and the line mask is at address 2.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the interrupt output is low, and the vector, base and mask registers all read 0, so every line is unmasked.
- R2: When several unmasked synchronized request lines are high together, the line with the lowest index is chosen.
- R3: The latched vector equals (base + chosen line index) modulo 256. The base is written and read back at address 1.
- R4: Suppose a request line goes high and stays high while the controller is idle, ahead of rising edge k. The interrupt output is still low after edge k+1 and is high, with the vector valid, after edge k+2.
- R5: While the interrupt output is high and no write to address 0 occurs, the output stays high and the vector does not change, even if a lower-index line is raised.
- R6: A write to address 0 while the interrupt output is high clears the output at the next edge. Arbitration restarts one cycle later, so the output stays low for at least one cycle.
- R7: Mask bit i, at address 2 and read back there, set to 1 keeps line i out of arbitration, so a request on a masked line alone never raises the interrupt output.
- R8: A write to address 0 while the interrupt output is low and no request is pending leaves the output low and the vector unchanged.
- R9: Reads of address 3 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_LINES | Asynchronous request lines, line 0 highest priority |
| bus_addr | input | 2 | Register address (0 vector/ack, 1 base, 2 mask) |
| bus_wr_en | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data of the addressed register |
| cpu_int | output | 1 | Interrupt request to the processor |

## Verification
The acknowledge write can arrive in the same cycle that the request lines change. The case of interest is a lower-index line being raised during the wait while an older, higher-index line stays high. The bench provokes this by raising line 1 while line 5's vector is held, then acknowledging. It requires the vector to stay on line 5 until the acknowledge, the output to drop for exactly one cycle, and line 1's vector to appear next. Seeded random masks, bases and request patterns, changed during each wait, are judged against a bench function that picks the lowest unmasked line.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int DATA_W = 8;
    localparam int REG_ADDR_W = 2;

    localparam logic [REG_ADDR_W-1:0] ADDR_VECTOR = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_BASE   = 2'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_MASK   = 2'd2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } irqc_state_e;

    typedef struct packed {
        irqc_state_e        st;
        logic [DATA_W-1:0]  vec;
    } irqc_ctl_t;

    // Vector arithmetic wraps modulo 2**DATA_W.
    function automatic logic [DATA_W-1:0] make_vector(
        input logic [DATA_W-1:0] base,
        input logic [DATA_W-1:0] line_idx
    );
        return base + line_idx;
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

    // Cycles since reset, saturating, so the delay check never reaches into reset.
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)               age_q <= 2'd0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    assert_two_stage_delay_R4: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd2) |-> (sync_out == $past(async_in, 2)));

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int WIDTH = 8,
    parameter int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] req,
    output logic             valid,
    output logic [IDX_W-1:0] idx,
    output logic [WIDTH-1:0] grant
);

    // Scan from the top down so the last hit, the lowest index, wins.
    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
            end
        end
    end

    assign valid = |req;

    assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && (valid == (grant != '0)));

    assert_grant_lowest_R2: assert property (@(posedge clk) disable iff (rst)
        valid |-> (((req & (grant - WIDTH'(1))) == '0) && ((req & grant) != '0)));

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_LINES-1:0]  irq_in,
    input  logic [1:0]            bus_addr,
    input  logic                  bus_wr_en,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    output logic                  cpu_int
);

    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    logic [NUM_LINES-1:0] irq_sync;
    logic [NUM_LINES-1:0] mask_q;
    logic [DATA_W-1:0]    base_q;
    logic [NUM_LINES-1:0] arb_req;
    logic                 arb_valid;
    logic [IDX_W-1:0]     arb_idx;
    logic [NUM_LINES-1:0] arb_grant;
    irqc_ctl_t            ctl_q;
    logic                 wr_vec;
    logic                 ack_hit;

    irqc_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (irq_in),
        .sync_out (irq_sync)
    );

    assign arb_req = irq_sync & ~mask_q;

    irqc_arbiter #(.WIDTH(NUM_LINES), .IDX_W(IDX_W)) u_arb (
        .clk   (clk),
        .rst   (rst),
        .req   (arb_req),
        .valid (arb_valid),
        .idx   (arb_idx),
        .grant (arb_grant)
    );

    assign wr_vec  = bus_wr_en && (bus_addr == ADDR_VECTOR);
    assign ack_hit = wr_vec && (ctl_q.st == ST_WAIT);

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            mask_q <= '0;
        end else if (bus_wr_en) begin
            if (bus_addr == ADDR_BASE) base_q <= bus_wdata;
            if (bus_addr == ADDR_MASK) mask_q <= bus_wdata[NUM_LINES-1:0];
        end
    end

    // Latch / hold / acknowledge handshake.
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.st  <= ST_IDLE;
            ctl_q.vec <= '0;
        end else begin
            unique case (ctl_q.st)
                ST_IDLE: begin
                    if (arb_valid) begin
                        ctl_q.vec <= make_vector(base_q, DATA_W'(arb_idx));
                        ctl_q.st  <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (ack_hit) ctl_q.st <= ST_IDLE;
                end
                default: ctl_q.st <= ST_IDLE;
            endcase
        end
    end

    assign cpu_int = (ctl_q.st == ST_WAIT);

    always_comb begin
        unique case (bus_addr)
            ADDR_VECTOR: bus_rdata = ctl_q.vec;
            ADDR_BASE:   bus_rdata = base_q;
            ADDR_MASK:   bus_rdata = DATA_W'(mask_q);
            default:     bus_rdata = '0;
        endcase
    end

    assert_no_masked_winner_R7: assert property (@(posedge clk) disable iff (rst)
        arb_valid |-> !mask_q[arb_idx] && irq_sync[arb_idx]);

    assert_vector_formed_R3: assert property (@(posedge clk) disable iff (rst)
        (!cpu_int && arb_valid) |=> cpu_int && (bus_addr != ADDR_VECTOR ||
            bus_rdata == DATA_W'($past(base_q) + DATA_W'($past(arb_idx)))));

    assert_int_held_R5: assert property (@(posedge clk) disable iff (rst)
        (cpu_int && !wr_vec) |=> cpu_int);

    assert_vector_stable_R5: assert property (@(posedge clk) disable iff (rst)
        cpu_int |=> $stable(ctl_q.vec));

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (cpu_int && wr_vec) |=> !cpu_int);

    assert_idle_write_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (!cpu_int && !arb_valid && wr_vec) |=> !cpu_int && $stable(ctl_q.vec));

endmodule

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] irq_in;
    logic [1:0]   bus_addr;
    logic         bus_wr_en;
    logic [7:0]   bus_wdata;
    logic [7:0]   bus_rdata;
    logic         cpu_int;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_prio_ctrl #(.NUM_LINES(N)) i_irq_prio_ctrl (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .bus_addr  (bus_addr),
        .bus_wr_en (bus_wr_en),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cpu_int   (cpu_int)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr_en = 1'b1;
        step(1);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Lowest-index unmasked raised line, and its vector.
    function automatic logic pick(input logic [N-1:0] pat, input logic [N-1:0] m,
                                  input logic [7:0] base, output logic [7:0] vec);
        vec = 8'h00;
        for (int i = 0; i < N; i++) begin
            if (pat[i] && !m[i]) begin
                vec = base + 8'(i);
                return 1'b1;
            end
        end
        return 1'b0;
    endfunction

    task automatic drain();
        irq_in = '0;
        step(3);
        if (cpu_int) bus_write(2'd0, 8'h00);
        step(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] exp_vec;
        logic       hit;
        void'($urandom(32'd20240611));
        rst = 1'b1; irq_in = '0; bus_addr = 2'd0; bus_wr_en = 1'b0; bus_wdata = '0;
        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state
        check("R1 int", 32'(cpu_int), 32'd0);
        bus_read(2'd0, rd); check("R1 vector", 32'(rd), 32'd0);
        bus_read(2'd1, rd); check("R1 base", 32'(rd), 32'd0);
        bus_read(2'd2, rd); check("R1 mask", 32'(rd), 32'd0);
        // R9 unused address
        bus_read(2'd3, rd); check("R9 addr3", 32'(rd), 32'd0);

        // R8 acknowledge write while idle
        bus_write(2'd0, 8'h5A);
        step(1);
        check("R8 int", 32'(cpu_int), 32'd0);
        bus_read(2'd0, rd); check("R8 vector", 32'(rd), 32'd0);

        // R4 latency and R3 base readback, then R5/R6 collision case
        bus_write(2'd1, 8'h40);
        bus_read(2'd1, rd); check("R3 base readback", 32'(rd), 32'h40);
        irq_in = 8'b0010_0000;              // line 5
        step(2);
        check("R4 int low after k+1", 32'(cpu_int), 32'd0);
        step(1);
        check("R4 int high after k+2", 32'(cpu_int), 32'd1);
        bus_read(2'd0, rd); check("R3 vector line5", 32'(rd), 32'h45);
        irq_in = 8'b0010_0010;              // raise line 1 during wait
        step(4);
        check("R5 int held", 32'(cpu_int), 32'd1);
        bus_read(2'd0, rd); check("R5 vector held", 32'(rd), 32'h45);
        bus_write(2'd0, 8'h00);
        check("R6 int cleared", 32'(cpu_int), 32'd0);
        step(1);
        check("R6 re-arbitrate", 32'(cpu_int), 32'd1);
        bus_read(2'd0, rd); check("R2 line1 wins", 32'(rd), 32'h41);
        drain();

        // R3 wrap of base + index
        bus_write(2'd1, 8'hFE);
        irq_in = 8'b1000_0000;
        step(3);
        bus_read(2'd0, rd); check("R3 wrap", 32'(rd), 32'h05);
        drain();

        // R7 masked line alone
        bus_write(2'd2, 8'h08);
        bus_read(2'd2, rd); check("R7 mask readback", 32'(rd), 32'h08);
        irq_in = 8'b0000_1000;
        step(6);
        check("R7 masked alone", 32'(cpu_int), 32'd0);
        drain();

        // Random mix
        for (int it = 0; it < 60; it++) begin
            logic [N-1:0] pat;
            logic [N-1:0] m;
            logic [7:0]   b;
            pat = N'($urandom);
            m   = N'($urandom & $urandom);
            b   = 8'($urandom);
            bus_write(2'd1, b);
            bus_write(2'd2, 8'(m));
            bus_read(2'd2, rd); check("R7 mask readback", 32'(rd), 32'(m));
            irq_in = pat;
            hit = pick(pat, m, b, exp_vec);
            step(2);
            check("R4 low before latch", 32'(cpu_int), 32'd0);
            step(1);
            if (hit) begin
                check("R4 int raised", 32'(cpu_int), 32'd1);
                bus_read(2'd0, rd); check("R2 R3 random vector", 32'(rd), 32'(exp_vec));
                irq_in = N'($urandom);
                step(3);
                check("R5 int held", 32'(cpu_int), 32'd1);
                bus_read(2'd0, rd); check("R5 vector held", 32'(rd), 32'(exp_vec));
                bus_write(2'd0, 8'($urandom));
                check("R6 ack clears", 32'(cpu_int), 32'd0);
            end else begin
                step(3);
                check("R7 no unmasked request", 32'(cpu_int), 32'd0);
            end
            drain();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule